// File: doc/BRIEF.md
# Thread Block Residency Allocator

This block decides whether a new thread block may become resident on one multiprocessor. It keeps the running totals for four resource pools: the register file, the shared-memory array, the warp (thread) slots and the block slots. A request gives the thread count of the block, the registers each thread needs and the shared-memory bytes of the block. The block rounds the thread count up to whole 32-thread warps and works out what the request would take from each pool. It grants the request only when all four pools can hold it at the same time.

A granted block gets the lowest-numbered free slot ID and its charges are recorded against that slot. A later release that names the slot returns exactly those amounts. A request that could never fit, even on an empty multiprocessor, is consumed at once and flagged as an error. A request that only lacks room at the moment is held, with ready low, until releases make room. The number of resident warps is always on an output and gives the occupancy directly, against a fixed maximum of 64 warps.

Top module: `blk_residency_alloc`

## Requirements
- R1: The warp count of a request is the thread count divided by 32, rounded up (160 threads make 5 warps, 161 make 6). A grant raises `resident_warps` by that count in the cycle after the handshake.
- R2: The register charge is warps × 32 × registers per thread. A request is granted only if the total charge of all resident blocks stays at or below 65,536.
- R3: The shared-memory charge is the request's byte count. The sum over resident blocks never exceeds 65,536 bytes.
- R4: The warp pool holds at most 64 warps (2048 threads). A request that would exceed it is not granted.
- R5: At most 16 blocks are resident. A 17th fitting request is not granted while all slots are busy.
- R6: A valid request that is well-formed but does not fit keeps `req_ready` low, and no grant appears. It is accepted as soon as releases make room.
- R7: In the cycle after an accepted, well-formed request, `grant_valid` is high for one cycle and `grant_slot` holds the lowest-numbered free slot.
- R8: A request is oversize when any of these holds: registers per thread > 255, thread count 0, or the charge to any one pool larger than that pool's capacity. An oversize request is accepted with `req_ready` high. `reject_err` is then high for exactly one cycle, no grant is given and no pool is charged.
- R9: A release of a busy slot returns that slot's recorded charges, and `resident_warps` shows this in the next cycle. A release of a free slot has no effect. `rel_ready` is always high.
- R10: After reset, `resident_warps` is 0, `grant_valid` and `reject_err` are low, and a fitting request sees `req_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Admission request present |
| req_ready | output | 1 | Request taken this cycle (grant or reject) |
| req_threads | input | 12 | Threads in the block |
| req_regs | input | 9 | Registers per thread |
| req_smem | input | 17 | Shared-memory bytes for the block |
| grant_valid | output | 1 | One-cycle pulse: request was granted |
| grant_slot | output | 4 | Slot ID assigned by the grant |
| reject_err | output | 1 | One-cycle pulse: oversize request dropped |
| rel_valid | input | 1 | Release request present |
| rel_ready | output | 1 | Release accepted (always high) |
| rel_slot | input | 4 | Slot ID to release |
| resident_warps | output | 7 | Warps now resident (occupancy numerator, max 64) |

## Verification
The bench fills each pool exactly to its capacity and then offers one more small request. This tests the `<=` boundary in every pool. A design that compared with `<` would refuse the exact fill, and one that checked only some pools would admit the extra block. Thread counts of 160 and 161 test the rounding. A design that charged raw threads or truncated would show the wrong `resident_warps`. A held request must stay blocked and then take the slot freed by a release, which catches designs that drop or double-grant stalled requests. Oversize requests and double releases must leave the totals unchanged, which exposes designs that charge before rejecting or that refund a free slot.

// File: rtl/tba_pkg.sv
package tba_pkg;
    localparam int WARP_SIZE   = 32;
    localparam int LOG_WS      = $clog2(WARP_SIZE);
    localparam int MAX_THREADS = 2048;
    localparam int MAX_BLOCKS  = 16;
    localparam int REG_FILE    = 65536;
    localparam int MAX_REGS    = 255;
    localparam int SMEM_BYTES  = 65536;

    localparam int MAX_WARPS = MAX_THREADS / WARP_SIZE;
    localparam int THR_W     = $clog2(MAX_THREADS) + 1;
    localparam int RPT_W     = $clog2(MAX_REGS + 1) + 1;
    localparam int SMEM_W    = $clog2(SMEM_BYTES) + 1;
    localparam int WARP_W    = THR_W + 1 - LOG_WS;
    localparam int SLOT_W    = $clog2(MAX_BLOCKS);
    localparam int OCC_W     = $clog2(MAX_WARPS + 1);
    localparam int AMT_W     = WARP_W + LOG_WS + RPT_W + 1;

    localparam int NPOOL  = 4;
    localparam int P_REG  = 0;
    localparam int P_SMEM = 1;
    localparam int P_WARP = 2;
    localparam int P_BLK  = 3;

    typedef logic [AMT_W-1:0] amt_t;
    typedef logic [NPOOL-1:0][AMT_W-1:0] pool_vec_t;

    function automatic int pool_cap(int idx);
        case (idx)
            P_REG:   return REG_FILE;
            P_SMEM:  return SMEM_BYTES;
            P_WARP:  return MAX_WARPS;
            default: return MAX_BLOCKS;
        endcase
    endfunction
endpackage

// File: rtl/tba_warp_round.sv
module tba_warp_round #(
    parameter int THR_W  = 12,
    parameter int LOG_WS = 5,
    parameter int WARP_W = THR_W + 1 - LOG_WS
) (
    input  logic [THR_W-1:0]  threads,
    output logic [WARP_W-1:0] warps
);
    localparam int WS = 1 << LOG_WS;

    logic [THR_W:0] padded;

    always_comb begin
        padded = {1'b0, threads} + (THR_W+1)'(WS - 1);
        warps  = padded[THR_W:LOG_WS];
    end
endmodule

// File: rtl/tba_pool.sv
module tba_pool #(
    parameter int W   = 23,
    parameter int CAP = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] need_amt,
    input  logic         charge,
    input  logic         refund,
    input  logic [W-1:0] refund_amt,
    output logic [W-1:0] used,
    output logic         fits
);
    localparam logic [W:0] CAP_V = (W+1)'(CAP);

    typedef struct packed {
        logic [W-1:0] used;
    } pool_st_t;

    pool_st_t s_d, s_q;

    always_comb begin
        s_d  = s_q;
        fits = ({1'b0, s_q.used} + {1'b0, need_amt}) <= CAP_V;
        if (charge) s_d.used = s_d.used + need_amt;
        if (refund) s_d.used = s_d.used - refund_amt;
        used = s_q.used;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R2, R3, R4, R5: one instance per pool, none may exceed its capacity
    a_r4_pool_le_cap: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, s_q.used} <= CAP_V);

    // R9: a refund never returns more than is outstanding
    a_r9_refund_covered: assert property (@(posedge clk) disable iff (!rst_n)
        refund |-> refund_amt <= s_q.used);
endmodule

// File: rtl/tba_slot_table.sv
module tba_slot_table
    import tba_pkg::*;
#(
    parameter int NSLOT = MAX_BLOCKS,
    parameter int SW    = SLOT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_en,
    input  pool_vec_t        alloc_vec,
    input  logic             rel_en,
    input  logic [SW-1:0]    rel_idx,
    output logic             free_avail,
    output logic [SW-1:0]    free_idx,
    output logic [NSLOT-1:0] busy,
    output pool_vec_t        rel_vec
);
    typedef struct packed {
        logic [NSLOT-1:0]            busy;
        pool_vec_t [NSLOT-1:0]       chg;
    } tab_st_t;

    tab_st_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        busy       = s_q.busy;
        free_avail = ~&s_q.busy;
        free_idx   = '0;
        for (int i = NSLOT - 1; i >= 0; i--) begin
            if (!s_q.busy[i]) free_idx = SW'(i);
        end
        rel_vec = s_q.chg[rel_idx];
        if (alloc_en) begin
            s_d.busy[free_idx] = 1'b1;
            s_d.chg[free_idx]  = alloc_vec;
        end
        if (rel_en) s_d.busy[rel_idx] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R7: the slot handed out is marked busy afterwards
    a_r7_alloc_marks_busy: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |=> s_q.busy[$past(free_idx)]);

    // R9: only busy slots are ever refunded
    a_r9_release_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        rel_en |-> s_q.busy[rel_idx]);
endmodule

// File: rtl/blk_residency_alloc.sv
module blk_residency_alloc
    import tba_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [THR_W-1:0]  req_threads,
    input  logic [RPT_W-1:0]  req_regs,
    input  logic [SMEM_W-1:0] req_smem,
    output logic              grant_valid,
    output logic [SLOT_W-1:0] grant_slot,
    output logic              reject_err,
    input  logic              rel_valid,
    output logic              rel_ready,
    input  logic [SLOT_W-1:0] rel_slot,
    output logic [OCC_W-1:0]  resident_warps
);
    typedef struct packed {
        logic              gv;
        logic [SLOT_W-1:0] gslot;
        logic              rej;
    } out_st_t;

    out_st_t o_d, o_q;

    logic [WARP_W-1:0]     warps;
    pool_vec_t             charge_vec;
    pool_vec_t             rel_vec;
    logic [NPOOL-1:0]      over;
    logic [NPOOL-1:0]      fits;
    amt_t                  used [NPOOL];
    logic                  slot_avail;
    logic [SLOT_W-1:0]     free_idx;
    logic [MAX_BLOCKS-1:0] busy;
    logic                  oversize, fits_all, accept, grant, reject, rel_fire;
    logic                  unused_bits;

    tba_warp_round #(.THR_W(THR_W), .LOG_WS(LOG_WS), .WARP_W(WARP_W)) u_round (
        .threads (req_threads),
        .warps   (warps)
    );

    always_comb begin
        charge_vec         = '0;
        charge_vec[P_REG]  = amt_t'(warps) * amt_t'(WARP_SIZE) * amt_t'(req_regs);
        charge_vec[P_SMEM] = amt_t'(req_smem);
        charge_vec[P_WARP] = amt_t'(warps);
        charge_vec[P_BLK]  = amt_t'(1);
    end

    for (genvar g = 0; g < NPOOL; g++) begin : g_pool
        localparam int CAP = pool_cap(g);
        assign over[g] = charge_vec[g] > amt_t'(CAP);
        tba_pool #(.W(AMT_W), .CAP(CAP)) u_pool (
            .clk        (clk),
            .rst_n      (rst_n),
            .need_amt   (charge_vec[g]),
            .charge     (grant),
            .refund     (rel_fire),
            .refund_amt (rel_vec[g]),
            .used       (used[g]),
            .fits       (fits[g])
        );
    end

    tba_slot_table #(.NSLOT(MAX_BLOCKS), .SW(SLOT_W)) u_slots (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc_en   (grant),
        .alloc_vec  (charge_vec),
        .rel_en     (rel_fire),
        .rel_idx    (rel_slot),
        .free_avail (slot_avail),
        .free_idx   (free_idx),
        .busy       (busy),
        .rel_vec    (rel_vec)
    );

    always_comb begin
        oversize  = (req_regs > RPT_W'(MAX_REGS)) || (req_threads == '0) || (|over);
        fits_all  = (&fits) && slot_avail;
        req_ready = oversize || fits_all;
        accept    = req_valid && req_ready;
        grant     = accept && !oversize;
        reject    = accept && oversize;
        rel_ready = 1'b1;
        rel_fire  = rel_valid && busy[rel_slot];

        o_d       = o_q;
        o_d.gv    = grant;
        o_d.rej   = reject;
        if (grant) o_d.gslot = free_idx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign grant_valid    = o_q.gv;
    assign grant_slot     = o_q.gslot;
    assign reject_err     = o_q.rej;
    assign resident_warps = used[P_WARP][OCC_W-1:0];
    assign unused_bits    = ^{used[P_REG], used[P_SMEM], used[P_WARP][AMT_W-1:OCC_W]};

    // R1: rounding covers every thread and wastes less than one warp
    a_r1_round_bounds: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (int'(warps) * WARP_SIZE >= int'(req_threads)) &&
                      (int'(warps) * WARP_SIZE <  int'(req_threads) + WARP_SIZE));

    // R1: a grant adds exactly its warp count to the occupancy
    a_r1_grant_adds_warps: assert property (@(posedge clk) disable iff (!rst_n)
        grant && !rel_fire |=>
            WARP_W'(resident_warps) == WARP_W'($past(resident_warps)) + $past(warps));

    // R8: a rejected request leaves occupancy untouched
    a_r8_reject_no_charge: assert property (@(posedge clk) disable iff (!rst_n)
        reject && !rel_fire |=> resident_warps == $past(resident_warps));

    // R9: releasing a free slot changes nothing
    a_r9_free_release_noop: assert property (@(posedge clk) disable iff (!rst_n)
        rel_valid && !busy[rel_slot] && !grant |=> resident_warps == $past(resident_warps));

    // R5: the block pool agrees with the slot table
    a_r5_blk_matches_slots: assert property (@(posedge clk) disable iff (!rst_n)
        used[P_BLK] == amt_t'($countones(busy)));

    // R7: a grant pulse and a reject pulse never coincide
    a_r7_single_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        !(grant_valid && reject_err));
endmodule

// File: tb/blk_residency_alloc_tb.sv
`timescale 1ns/1ps
module blk_residency_alloc_tb_top;
    import tba_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [THR_W-1:0]  req_threads = '0;
    logic [RPT_W-1:0]  req_regs = '0;
    logic [SMEM_W-1:0] req_smem = '0;
    logic              grant_valid;
    logic [SLOT_W-1:0] grant_slot;
    logic              reject_err;
    logic              rel_valid = 1'b0;
    logic              rel_ready;
    logic [SLOT_W-1:0] rel_slot = '0;
    logic [OCC_W-1:0]  resident_warps;

    always #2.5 clk = ~clk;

    blk_residency_alloc dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_threads(req_threads), .req_regs(req_regs), .req_smem(req_smem),
        .grant_valid(grant_valid), .grant_slot(grant_slot), .reject_err(reject_err),
        .rel_valid(rel_valid), .rel_ready(rel_ready), .rel_slot(rel_slot),
        .resident_warps(resident_warps)
    );

    int n_chk = 0;
    int n_fail = 0;
    int exp_q[$];
    bit mbusy [MAX_BLOCKS];
    int mw [MAX_BLOCKS];
    int model_res = 0;
    int e;

    task automatic chk(bit ok, string tag, int act, int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    function automatic int lowest_free();
        for (int i = 0; i < MAX_BLOCKS; i++) if (!mbusy[i]) return i;
        return -1;
    endfunction

    // driver: offers a request, waits for ready, pushes the expected outcome
    task automatic send_req(int thr, int regs, int smem, bit bad, string tag);
        int s;
        int guard;
        @(negedge clk);
        req_valid   = 1'b1;
        req_threads = THR_W'(thr);
        req_regs    = RPT_W'(regs);
        req_smem    = SMEM_W'(smem);
        #1;
        guard = 0;
        while (!req_ready && guard < 2000) begin
            @(negedge clk); #1; guard++;
        end
        chk(req_ready, tag, int'(req_ready), 1);
        if (bad) exp_q.push_back(-1);
        else begin
            s = lowest_free();
            exp_q.push_back(s);
            if (s >= 0) begin
                mbusy[s]  = 1'b1;
                mw[s]     = (thr + WARP_SIZE - 1) / WARP_SIZE;
                model_res += mw[s];
            end
        end
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic rel(int s);
        @(negedge clk);
        rel_valid = 1'b1;
        rel_slot  = SLOT_W'(s);
        @(posedge clk);
        if (mbusy[s]) begin
            mbusy[s]  = 1'b0;
            model_res -= mw[s];
        end
        #1;
        rel_valid = 1'b0;
    endtask

    task automatic chk_res(string tag);
        @(negedge clk);
        chk(int'(resident_warps) == model_res, tag, int'(resident_warps), model_res);
    endtask

    // offers a request that must not be taken, then withdraws it before the edge
    task automatic probe(int thr, int regs, int smem, string tag);
        @(negedge clk);
        req_valid   = 1'b1;
        req_threads = THR_W'(thr);
        req_regs    = RPT_W'(regs);
        req_smem    = SMEM_W'(smem);
        #1;
        chk(!req_ready, tag, int'(req_ready), 0);
        #0.5;
        req_valid = 1'b0;
    endtask

    // monitor: pops the scoreboard on every outcome pulse
    always @(negedge clk) begin
        if (rst_n && (grant_valid || reject_err)) begin
            if (exp_q.size() == 0) chk(1'b0, "R7 unexpected outcome", int'(grant_valid), 0);
            else begin
                e = exp_q.pop_front();
                if (e < 0) chk(reject_err && !grant_valid, "R8 reject pulse", int'(reject_err), 1);
                else chk(grant_valid && int'(grant_slot) == e, "R7 grant slot", int'(grant_slot), e);
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R10: reset state
        @(negedge clk);
        chk(resident_warps == '0, "R10 resident after reset", int'(resident_warps), 0);
        chk(!grant_valid && !reject_err, "R10 pulses low", int'(grant_valid | reject_err), 0);
        req_valid = 1'b1; req_threads = 12'd32; req_regs = 9'd1; req_smem = '0;
        #1 chk(req_ready, "R10 ready for fitting request", int'(req_ready), 1);
        #0.5 req_valid = 1'b0;

        // R1: rounding to warps
        send_req(160, 8, 1024, 1'b0, "R1 160 threads");
        chk_res("R1 resident model");
        chk(resident_warps == 7'd5, "R1 160 threads -> 5 warps", int'(resident_warps), 5);
        send_req(161, 8, 1024, 1'b0, "R1 161 threads");
        @(negedge clk);
        chk(resident_warps == 7'd11, "R1 161 threads -> 6 warps", int'(resident_warps), 11);

        // R9: release and double release
        rel(0);
        chk_res("R9 release returns warps");
        rel(0);
        chk_res("R9 free-slot release no effect");

        // R7: lowest free slot reused
        send_req(32, 4, 0, 1'b0, "R7 lowest slot");
        chk_res("R7 resident");

        // R8: oversize requests
        send_req(32, 256, 0, 1'b1, "R8 regs over limit");
        @(negedge clk); @(negedge clk);
        chk(!reject_err, "R8 reject lasts one cycle", int'(reject_err), 0);
        chk_res("R8 no charge");
        send_req(0, 1, 0, 1'b1, "R8 zero threads");
        send_req(32, 1, 65537, 1'b1, "R8 smem over array");
        send_req(2048, 64, 0, 1'b1, "R2 register charge over pool");
        chk_res("R8 totals unchanged");
        rel(0); rel(1);
        chk_res("R9 empty");

        // R2 and R6: exact register fill, then a held request
        send_req(1024, 64, 0, 1'b0, "R2 exact register fill");
        chk_res("R2 resident 32");
        fork
            send_req(32, 1, 0, 1'b0, "R6 held request");
        join_none
        repeat (4) @(negedge clk);
        #1 chk(!req_ready, "R6 ready low while full", int'(req_ready), 0);
        rel(0);
        repeat (4) @(negedge clk);
        chk(int'(resident_warps) == 1, "R6 held request granted", int'(resident_warps), 1);
        rel(0);
        chk_res("R9 empty again");

        // R3: shared memory exact fill then one more byte
        send_req(32, 1, 32768, 1'b0, "R3 half smem");
        send_req(32, 1, 32768, 1'b0, "R3 full smem");
        probe(32, 1, 1, "R3 one byte over");
        rel(0); rel(1);

        // R4: warp pool exact fill
        send_req(2048, 1, 0, 1'b0, "R4 full warps");
        chk_res("R4 resident 64");
        probe(32, 1, 0, "R4 warp 65 refused");
        rel(0);

        // R5: block slots
        for (int i = 0; i < MAX_BLOCKS; i++) send_req(32, 1, 0, 1'b0, "R5 fill slot");
        chk_res("R5 sixteen blocks");
        probe(32, 1, 0, "R5 seventeenth block refused");
        rel(7);
        send_req(64, 1, 0, 1'b0, "R7 freed middle slot");
        chk_res("R7 resident after refill");
        for (int i = 0; i < MAX_BLOCKS; i++) rel(i);
        chk_res("R9 all released");

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R7 outstanding outcomes", exp_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule